// File: doc/BRIEF.md
# Receive chunk footer parser

This block sits on the receive side of a serial link to a combined MAC and PHY device. Data arrives as fixed-size chunks: a payload of `CHUNK_BYTES` bytes followed by a 32-bit trailer word. The trailer tells the block whether the payload carries frame data and where a frame starts and ends inside it. The block holds each payload in one half of a two-bank store until its trailer arrives. It then checks the trailer and replays the valid bytes as a byte stream, marking the first and last byte of each reassembled Ethernet frame. It also signals when a frame in progress has to be thrown away.

The trailer also carries flow-control and status information. The block passes it to a transfer controller: the number of free transmit buffers, the number of receive chunks waiting, and an error-summary flag. From these, and from an interrupt line, the block asks the controller for empty exchanges. It asks for one exchange when the interrupt rises, so that the next trailer reveals the cause. When chunks are waiting, it asks for as many exchanges as there are chunks. When the error flag is set, it raises a one-cycle request to read the device status register.

Top module: `rx_footer_parser`

## Requirements
- R1: After reset, every output is 0: no frame bytes, no abort, no requests, and all status counts cleared.
- R2: A chunk is `CHUNK_BYTES` payload bytes followed by four trailer bytes, most significant byte first. A trailer with good parity updates the outputs as follows: `tx_credits` takes bits 5:1, `rx_chunks` takes bits 28:24 and `ext_flag` takes bit 31.
- R3: The trailer uses odd parity over all 32 bits, with bit 0 as the parity bit. A trailer with bad parity has these effects:
  - it pulses `footer_err`;
  - it leaves all status outputs unchanged;
  - its payload is discarded;
  - an open frame is closed with a `fr_abort` pulse.
- R4: When bit 21 (data present) of a good trailer is 0, the chunk emits no frame bytes and leaves the open/closed frame state unchanged, whatever the other marker bits say.
- R5: A frame starts when bit 20 (start present) is set. The start position is four times the word offset in bits 19:16. The byte at that position is emitted with `fr_first`. Bytes after it follow to the end of the payload unless an end marker closes the frame first.
- R6: A frame ends when bit 14 (end present) is set. The end position is the byte offset in bits 13:8, and the byte there is emitted with `fr_last`. A good data chunk with neither marker forwards all of its bytes while a frame is open.
- R7: When both markers are set and the end position is not before the start position, the chunk holds one complete frame. When the end position is before the start position, the chunk first ends the open frame and then begins a new one.
- R8: Data in a chunk whose end marker or continuation has no open frame before it is dropped, including the ended byte.
- R9: A start marker that arrives while a frame is open aborts the old frame with a `fr_abort` pulse, and the old frame gets no `fr_last`. The exception is the ordering of R7, where the old frame ends before the start position.
- R10: A rising `irq` produces one `xfer_req` pulse with `xfer_count` = 1.
- R11: A good trailer with a nonzero receive-chunk count produces one `xfer_req` pulse with `xfer_count` equal to that count. A good trailer with a zero count produces no request.
- R12: A good trailer with bit 31 set produces one `stat_read_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_byte | input | 8 | Received byte, payload first, then the trailer |
| irq | input | 1 | Device interrupt, level, already synchronous |
| fr_valid | output | 1 | Frame byte present |
| fr_data | output | 8 | Frame byte |
| fr_first | output | 1 | First byte of a frame |
| fr_last | output | 1 | Last byte of a frame |
| fr_abort | output | 1 | Open frame discarded |
| tx_credits | output | 5 | Free transmit buffers from the last good trailer |
| rx_chunks | output | 5 | Waiting receive chunks from the last good trailer |
| ext_flag | output | 1 | Error-summary flag from the last good trailer |
| footer_err | output | 1 | Pulse: trailer failed parity |
| xfer_req | output | 1 | Pulse: request empty exchanges |
| xfer_count | output | 5 | Number of exchanges requested |
| stat_read_req | output | 1 | Pulse: request a status register read |

## Verification
The bench builds the block with `CHUNK_BYTES` = 16. With that size, every legal start word offset (0 to 3) and every end byte offset inside the payload can be swept. The sweep covers every combination of start and end markers, each with a frame open and with a frame closed beforehand. This brings every ordering of start and end positions within reach, including equal positions and an end before the start. Directed chunks then cover bad parity, a cleared data-present bit, the interrupt and the counts that drive requests.

// File: rtl/rxfp_pkg.sv
// Shared trailer layout and parity helper for the receive chunk footer parser.
package rxfp_pkg;

    // Trailer word layout; reserved fields are ignored.
    typedef struct packed {
        logic       ext;
        logic [1:0] rsv_a;
        logic [4:0] rca;
        logic [1:0] rsv_b;
        logic       dv;
        logic       sv;
        logic [3:0] swo;
        logic       rsv_c;
        logic       ev;
        logic [5:0] ebo;
        logic [1:0] rsv_d;
        logic [4:0] txc;
        logic       par;
    } footer_t;

    // Odd parity over the whole word: good when the count of ones is odd.
    function automatic logic footer_good(input logic [31:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/rxfp_chunk_collect.sv
// Chunk collector.
// Counts incoming bytes into payload and trailer, writes payload bytes
// into one bank of a two-bank store and hands the finished trailer and
// the bank number on with a one-cycle done pulse.
// Assumes the byte stream starts aligned to a chunk after reset and that
// CHUNK_BYTES is a power of two.
module rxfp_chunk_collect #(
    parameter int CHUNK_BYTES = 64,
    localparam int IDX_W = $clog2(CHUNK_BYTES),
    localparam int CNT_W = $clog2(CHUNK_BYTES + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic [31:0]      footer,
    output logic             done_bank
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHUNK_BYTES + 3);
    localparam logic [CNT_W-1:0] PAY  = CNT_W'(CHUNK_BYTES);

    logic [CNT_W-1:0] cnt;
    logic             bank;
    logic [23:0]      shift;
    logic [7:0]       store [2*CHUNK_BYTES];

    // Byte position tracking, trailer capture and bank switching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            bank      <= 1'b0;
            shift     <= '0;
            done      <= 1'b0;
            footer    <= '0;
            done_bank <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rx_valid) begin
                if (cnt == LAST) begin
                    cnt       <= '0;
                    done      <= 1'b1;
                    footer    <= {shift, rx_byte};
                    done_bank <= bank;
                    bank      <= ~bank;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (cnt >= PAY) shift <= {shift[15:0], rx_byte};
                end
            end
        end
    end

    // Payload store write; the data needs no reset.
    always_ff @(posedge clk) begin
        if (rx_valid && cnt < PAY) store[{bank, cnt[IDX_W-1:0]}] <= rx_byte;
    end

    // Asynchronous read port for the frame extractor.
    assign rd_data = store[{rd_bank, rd_idx}];

endmodule

// File: rtl/rxfp_frame_extract.sv
// Frame extractor.
// On each good trailer with data present, replays the stored payload one
// byte per cycle and emits the bytes that lie inside a frame, with first
// and last markers. Aborts an open frame on a bad trailer or on a start
// marker that does not follow an earlier end in the same chunk.
// Assumes a drain of CHUNK_BYTES cycles ends before the next done pulse,
// which holds because each chunk takes at least CHUNK_BYTES+4 bytes.
module rxfp_frame_extract
    import rxfp_pkg::*;
#(
    parameter int CHUNK_BYTES = 64,
    localparam int IDX_W = $clog2(CHUNK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [31:0]      footer,
    input  logic             done_bank,
    output logic             rd_bank,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output logic             fr_valid,
    output logic [7:0]       fr_data,
    output logic             fr_first,
    output logic             fr_last,
    output logic             fr_abort
);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(CHUNK_BYTES - 1);

    footer_t    f;
    logic [7:0] f_start, f_end;
    logic       good, pre_abort;

    logic             busy, in_frame, sv_r, ev_r, bank_r;
    logic [IDX_W-1:0] idx;
    logic [7:0]       start_r, end_r, idx_e;
    logic             starting, active, ending;

    // Decode the arriving trailer into byte positions.
    always_comb begin
        f         = footer_t'(footer);
        f_start   = {2'b00, f.swo, 2'b00};
        f_end     = {2'b00, f.ebo};
        good      = footer_good(footer);
        pre_abort = in_frame && f.sv && !(f.ev && f_end < f_start);
    end

    // Per-byte frame membership during a drain.
    always_comb begin
        idx_e    = 8'(idx);
        starting = busy && sv_r && idx_e == start_r;
        active   = starting || (busy && in_frame);
        ending   = ev_r && idx_e == end_r && active;
    end

    // Drain sequencing, frame state and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            in_frame <= 1'b0;
            sv_r     <= 1'b0;
            ev_r     <= 1'b0;
            bank_r   <= 1'b0;
            idx      <= '0;
            start_r  <= '0;
            end_r    <= '0;
            fr_valid <= 1'b0;
            fr_data  <= '0;
            fr_first <= 1'b0;
            fr_last  <= 1'b0;
            fr_abort <= 1'b0;
        end else begin
            fr_valid <= 1'b0;
            fr_first <= 1'b0;
            fr_last  <= 1'b0;
            fr_abort <= 1'b0;
            if (busy) begin
                fr_valid <= active;
                fr_data  <= rd_data;
                fr_first <= starting;
                fr_last  <= ending;
                in_frame <= active && !ending;
                idx      <= idx + 1'b1;
                if (idx == IDX_END) busy <= 1'b0;
            end
            if (done) begin
                if (!good) begin
                    fr_abort <= in_frame;
                    in_frame <= 1'b0;
                end else if (f.dv) begin
                    busy    <= 1'b1;
                    idx     <= '0;
                    bank_r  <= done_bank;
                    sv_r    <= f.sv;
                    ev_r    <= f.ev;
                    start_r <= f_start;
                    end_r   <= f_end;
                    if (pre_abort) begin
                        fr_abort <= 1'b1;
                        in_frame <= 1'b0;
                    end
                end
            end
        end
    end

    assign rd_bank = bank_r;
    assign rd_idx  = idx;

endmodule

// File: rtl/rxfp_status_track.sv
// Status tracker.
// Holds the flow-control and status fields of the last good trailer and
// issues exchange and status-read requests to the transfer controller.
// Assumes irq is already synchronous to clk.
module rxfp_status_track
    import rxfp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        done,
    input  logic [31:0] footer,
    input  logic        irq,
    output logic [4:0]  tx_credits,
    output logic [4:0]  rx_chunks,
    output logic        ext_flag,
    output logic        footer_err,
    output logic        xfer_req,
    output logic [4:0]  xfer_count,
    output logic        stat_read_req
);
    footer_t f;
    logic    good_done, bad_done, irq_q, irq_rise, want_rx;

    // Qualify the trailer and find the interrupt edge.
    always_comb begin
        f         = footer_t'(footer);
        good_done = done && footer_good(footer);
        bad_done  = done && !footer_good(footer);
        irq_rise  = irq && !irq_q;
        want_rx   = good_done && f.rca != 5'd0;
    end

    // Status registers and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q         <= 1'b0;
            tx_credits    <= '0;
            rx_chunks     <= '0;
            ext_flag      <= 1'b0;
            footer_err    <= 1'b0;
            xfer_req      <= 1'b0;
            xfer_count    <= '0;
            stat_read_req <= 1'b0;
        end else begin
            irq_q         <= irq;
            footer_err    <= bad_done;
            stat_read_req <= good_done && f.ext;
            xfer_req      <= want_rx || irq_rise;
            xfer_count    <= want_rx ? f.rca : 5'd1;
            if (good_done) begin
                tx_credits <= f.txc;
                rx_chunks  <= f.rca;
                ext_flag   <= f.ext;
            end
        end
    end

endmodule

// File: rtl/rx_footer_parser.sv
// Receive chunk footer parser, top level.
// Connects the chunk collector, the frame extractor and the status
// tracker. Assumes the chunk stream is aligned after reset.
module rx_footer_parser #(
    parameter int CHUNK_BYTES = 64,
    localparam int IDX_W = $clog2(CHUNK_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       irq,
    output logic       fr_valid,
    output logic [7:0] fr_data,
    output logic       fr_first,
    output logic       fr_last,
    output logic       fr_abort,
    output logic [4:0] tx_credits,
    output logic [4:0] rx_chunks,
    output logic       ext_flag,
    output logic       footer_err,
    output logic       xfer_req,
    output logic [4:0] xfer_count,
    output logic       stat_read_req
);
    logic             done, done_bank, rd_bank;
    logic [31:0]      footer;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;

    rxfp_chunk_collect #(.CHUNK_BYTES(CHUNK_BYTES)) u_collect (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
        .done(done), .footer(footer), .done_bank(done_bank)
    );

    rxfp_frame_extract #(.CHUNK_BYTES(CHUNK_BYTES)) u_extract (
        .clk(clk), .rst_n(rst_n), .done(done), .footer(footer),
        .done_bank(done_bank), .rd_bank(rd_bank), .rd_idx(rd_idx),
        .rd_data(rd_data), .fr_valid(fr_valid), .fr_data(fr_data),
        .fr_first(fr_first), .fr_last(fr_last), .fr_abort(fr_abort)
    );

    rxfp_status_track u_status (
        .clk(clk), .rst_n(rst_n), .done(done), .footer(footer), .irq(irq),
        .tx_credits(tx_credits), .rx_chunks(rx_chunks), .ext_flag(ext_flag),
        .footer_err(footer_err), .xfer_req(xfer_req),
        .xfer_count(xfer_count), .stat_read_req(stat_read_req)
    );

endmodule

// File: rtl/rxfp_checker.sv
// Property checker for the receive chunk footer parser, bound to the top.
module rxfp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fr_valid,
    input logic       fr_first,
    input logic       fr_last,
    input logic       fr_abort,
    input logic [4:0] tx_credits,
    input logic [4:0] rx_chunks,
    input logic       ext_flag,
    input logic       footer_err,
    input logic       xfer_req,
    input logic [4:0] xfer_count,
    input logic       stat_read_req
);
    // R5: a start marker always travels with a byte.
    a_r5_first_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        fr_first |-> fr_valid);

    // R6: an end marker always travels with a byte.
    a_r6_last_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        fr_last |-> fr_valid);

    // R9: an abort never coincides with a frame byte.
    a_r9_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
        fr_abort |-> !fr_valid);

    // R3: a bad trailer leaves the status unchanged.
    a_r3_bad_footer_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        footer_err |-> ($stable(tx_credits) && $stable(rx_chunks) && $stable(ext_flag)));

    // R10: every exchange request asks for at least one exchange.
    a_r10_xfer_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> xfer_count != 5'd0);

    // R12: a status read request comes with the error flag.
    a_r12_stat_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
        stat_read_req |-> ext_flag);

    // R3: a bad trailer never raises a status read request at the same time.
    a_r3_err_no_stat_req: assert property (@(posedge clk) disable iff (!rst_n)
        footer_err |-> !stat_read_req);
endmodule

bind rx_footer_parser rxfp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_first(fr_first),
    .fr_last(fr_last), .fr_abort(fr_abort), .tx_credits(tx_credits),
    .rx_chunks(rx_chunks), .ext_flag(ext_flag), .footer_err(footer_err),
    .xfer_req(xfer_req), .xfer_count(xfer_count), .stat_read_req(stat_read_req)
);

// File: tb/rx_footer_parser_test.sv
// Self-checking bench: marker sweep over a 16-byte chunk plus directed cases.
module rx_footer_parser_test;
    localparam int CB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       irq = 1'b0;
    logic       fr_valid, fr_first, fr_last, fr_abort;
    logic [7:0] fr_data;
    logic [4:0] tx_credits, rx_chunks, xfer_count;
    logic       ext_flag, footer_err, xfer_req, stat_read_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int seq = 0;
    bit m_open = 0;
    int exp_txc = 0, exp_rca = 0, exp_ext = 0;
    int xfer_n = 0, xfer_last = 0, sr_n = 0, fe_n = 0;
    logic [10:0] exp_q[$];
    logic [10:0] act_q[$];

    always #4 clk = ~clk;

    rx_footer_parser #(.CHUNK_BYTES(CB)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .irq(irq), .fr_valid(fr_valid), .fr_data(fr_data),
        .fr_first(fr_first), .fr_last(fr_last), .fr_abort(fr_abort),
        .tx_credits(tx_credits), .rx_chunks(rx_chunks), .ext_flag(ext_flag),
        .footer_err(footer_err), .xfer_req(xfer_req),
        .xfer_count(xfer_count), .stat_read_req(stat_read_req)
    );

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fr_abort) act_q.push_back(11'h400);
            if (fr_valid) act_q.push_back({1'b0, fr_first, fr_last, fr_data});
            if (xfer_req) begin xfer_n++; xfer_last = int'(xfer_count); end
            if (stat_read_req) sr_n++;
            if (footer_err) fe_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int s, input int i);
        return 8'(s * 29 + i * 7 + 3);
    endfunction

    function automatic logic [31:0] mkf(input bit ext, input int rca, input bit dv,
                                        input bit sv, input int swo, input bit ev,
                                        input int ebo, input int txc, input bit bad);
        logic [31:0] w;
        w = '0;
        w[31] = ext; w[28:24] = rca[4:0]; w[21] = dv; w[20] = sv;
        w[19:16] = swo[3:0]; w[14] = ev; w[13:8] = ebo[5:0]; w[5:1] = txc[4:0];
        w[0] = ~(^w[31:1]) ^ bad;
        return w;
    endfunction

    // Expected events for one chunk, from the requirement text.
    task automatic model_chunk(input logic [31:0] w);
        int s, e;
        bit starting, active, ending;
        if (!(^w)) begin
            if (m_open) exp_q.push_back(11'h400);
            m_open = 0;
            return;
        end
        exp_txc = int'(w[5:1]); exp_rca = int'(w[28:24]); exp_ext = int'(w[31]);
        if (!w[21]) return;
        s = int'(w[19:16]) * 4;
        e = int'(w[13:8]);
        if (m_open && w[20] && !(w[14] && e < s)) begin
            exp_q.push_back(11'h400);
            m_open = 0;
        end
        for (int i = 0; i < CB; i++) begin
            starting = w[20] && i == s;
            active   = starting || m_open;
            ending   = w[14] && i == e && active;
            if (active) exp_q.push_back({1'b0, starting, ending, pbyte(seq, i)});
            m_open = active && !ending;
        end
    endtask

    task automatic send_chunk(input logic [31:0] w);
        model_chunk(w);
        for (int i = 0; i < CB + 4; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = (i < CB) ? pbyte(seq, i) : w[(31 - 8 * (i - CB)) -: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        seq++;
    endtask

    task automatic settle_compare(input string tag);
        int bad_at;
        repeat (CB + 8) @(negedge clk);
        bad_at = -1;
        if (act_q.size() == exp_q.size()) begin
            for (int i = 0; i < act_q.size(); i++)
                if (bad_at < 0 && act_q[i] !== exp_q[i]) bad_at = i;
        end else bad_at = 0;
        if (bad_at < 0) chk(1'b1, tag, 0, 0);
        else if (act_q.size() != exp_q.size())
            chk(1'b0, {tag, " event count"}, act_q.size(), exp_q.size());
        else
            chk(1'b0, {tag, " event"}, int'(act_q[bad_at]), int'(exp_q[bad_at]));
        act_q.delete();
        exp_q.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int x0, s0, f0;
        string tag;
        repeat (5) @(negedge clk);
        // R1: reset state.
        chk(fr_valid == 0 && fr_abort == 0, "R1 frame outputs idle", int'(fr_valid), 0);
        chk(tx_credits == 0 && rx_chunks == 0 && ext_flag == 0, "R1 status cleared",
            int'(tx_credits), 0);
        chk(xfer_req == 0 && stat_read_req == 0 && footer_err == 0, "R1 requests idle",
            int'(xfer_req), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Marker sweep: open or closed beforehand, every marker pair and offset.
        x0 = xfer_n;
        for (int op = 0; op < 2; op++)
            for (int sv = 0; sv < 2; sv++)
                for (int ev = 0; ev < 2; ev++)
                    for (int swo = 0; swo < CB / 4; swo++)
                        for (int ebo = 0; ebo < CB; ebo++) begin
                            if (op != 0) send_chunk(mkf(0, 0, 1, 1, 0, 0, 0, 3, 0));
                            else send_chunk(mkf(0, 0, 1, 0, 0, 1, 0, 4, 0));
                            send_chunk(mkf(0, 0, 1, sv[0], swo, ev[0], ebo,
                                           (swo * CB + ebo) % 32, 0));
                            if (sv != 0 && ev != 0) tag = "R7";
                            else if (sv != 0) tag = (op != 0) ? "R9" : "R5";
                            else tag = (op != 0) ? "R6" : "R8";
                            settle_compare({tag, " marker sweep"});
                            chk(int'(tx_credits) == exp_txc, "R2 credit field",
                                int'(tx_credits), exp_txc);
                        end
        chk(xfer_n == x0, "R11 zero count makes no request", xfer_n - x0, 0);

        // R3: bad parity while a frame is open.
        send_chunk(mkf(0, 0, 1, 1, 1, 0, 0, 9, 0));
        settle_compare("R5 open frame");
        f0 = fe_n;
        send_chunk(mkf(1, 7, 1, 0, 0, 1, 5, 22, 1));
        send_chunk(mkf(0, 0, 1, 0, 0, 0, 0, 9, 0));
        settle_compare("R3 abort and discard");
        chk(fe_n == f0 + 1, "R3 footer_err pulse", fe_n - f0, 1);
        chk(int'(tx_credits) == 9 && rx_chunks == 0 && ext_flag == 0,
            "R3 status unchanged", int'(tx_credits), 9);

        // R4: data-present clear ignores the markers.
        send_chunk(mkf(0, 0, 1, 1, 2, 0, 0, 1, 0));
        send_chunk(mkf(0, 0, 0, 1, 0, 1, 3, 2, 0));
        send_chunk(mkf(0, 0, 1, 0, 0, 1, 4, 3, 0));
        settle_compare("R4 no data chunk");

        // R10: interrupt asks for one exchange.
        x0 = xfer_n;
        @(negedge clk); irq = 1'b1;
        repeat (3) @(negedge clk); irq = 1'b0;
        repeat (3) @(negedge clk);
        chk(xfer_n == x0 + 1, "R10 one request", xfer_n - x0, 1);
        chk(xfer_last == 1, "R10 count one", xfer_last, 1);

        // R11: waiting chunks set the request count.
        x0 = xfer_n;
        send_chunk(mkf(0, 5, 0, 0, 0, 0, 0, 6, 0));
        repeat (4) @(negedge clk);
        chk(xfer_n == x0 + 1, "R11 one request", xfer_n - x0, 1);
        chk(xfer_last == 5, "R11 count", xfer_last, 5);
        chk(int'(rx_chunks) == 5, "R2 chunk field", int'(rx_chunks), 5);

        // R12: error flag asks for a status read.
        s0 = sr_n;
        send_chunk(mkf(1, 0, 0, 0, 0, 0, 0, 6, 0));
        repeat (4) @(negedge clk);
        chk(sr_n == s0 + 1, "R12 status read pulse", sr_n - s0, 1);
        chk(ext_flag == 1'b1, "R2 error flag set", int'(ext_flag), 1);
        send_chunk(mkf(0, 0, 0, 0, 0, 0, 0, 6, 0));
        repeat (4) @(negedge clk);
        chk(sr_n == s0 + 1, "R12 no read when clear", sr_n - s0, 1);
        chk(ext_flag == 1'b0, "R2 error flag clear", int'(ext_flag), 0);
        settle_compare("R4 status-only chunks");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule